// File: doc/BRIEF.md
# LIN Frame Response Controller

This block runs the byte-level part of a LIN frame once break and sync are done. A one-cycle `frame_start` pulse loads a per-frame configuration and a 6-bit frame identifier. The configuration sets the node role (master or slave), the node action, and whether parity is used. It also sets whether a checksum is used, which checksum variant applies, and how the response length is found. A master sends the protected identifier byte. A slave receives that byte and checks its parity.

After the header, the node action picks one of three paths. A publishing node forwards bytes from a byte-write port to the transmit port. A subscribing node forwards bytes from the receive port to a byte-read port. An ignoring node moves no data and goes back to idle. In the first two cases a checksum byte can follow the data: it is appended on transmit and verified on receive. A one-cycle done pulse marks the end of the response. Sticky flags report a parity mismatch, a checksum mismatch and an ignored frame. Every byte port uses a valid/ready handshake with no storage inside the block, so a byte moves in the cycle where both sides agree.

Top module: `lin_resp_ctrl`

## Requirements
- R1: After synchronous active-low reset, `tx_valid`, `rx_ready`, `wr_ready`, `rd_valid`, `resp_done` and the three error flags are all 0.
- R2: A master sends the protected identifier byte first. Bits 5:0 carry the identifier. With parity enabled, bit 6 is id0^id1^id2^id4 and bit 7 is the inverse of id1^id3^id4^id5. With parity disabled, bits 7:6 are 0.
- R3: A slave takes the first received byte as the protected identifier and uses its bits 5:0 as the identifier. With parity enabled, `err_parity` is set when bits 7:6 differ from the rule of R2. With parity disabled, `err_parity` is never set.
- R4: With `cfg_len_by_id` = 0, the response holds `cfg_len_field` + 1 data bytes, which gives 1 to 256 when the field is 8 bits wide.
- R5: With `cfg_len_by_id` = 1, the identifier bits 5:4 set the data byte count: 00 gives 2, 01 gives 2, 10 gives 4, and 11 gives 8.
- R6: Action code 00 (publish) passes each data byte from the write port to the transmit port, in order.
- R7: Action code 01 (subscribe) passes each data byte from the receive port to the read port, in order.
- R8: Action codes 10 and 11 set `err_ignore` at the end of the header. No data or checksum byte moves, no done pulse follows, and the block idles until the next `frame_start`.
- R9: When publishing with the checksum enabled, the block sends one more byte after the data. That byte is the inverse of the end-around-carry sum of the data bytes. When `cfg_chk_classic` = 0 (enhanced), the sum also includes the protected identifier byte. When it is 1 (classic), the sum covers the data bytes only.
- R10: When subscribing with the checksum enabled, the block consumes one byte after the data. It sets `err_chk` unless the end-around-carry sum of that byte and the R9 sum equals 0xFF.
- R11: With the checksum disabled, no checksum byte is sent or consumed, and `err_chk` stays 0.
- R12: `resp_done` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the last byte of the response.
- R13: `frame_start` clears all three error flags. They read 0 in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that loads the configuration and identifier and begins the header |
| cfg_master | input | 1 | 1 selects the master role, 0 the slave role |
| cfg_action | input | 2 | Node action: 00 publish, 01 subscribe, 10 ignore, 11 reserved (handled as ignore) |
| cfg_parity_off | input | 1 | 1 turns off identifier parity generation and checking |
| cfg_chk_off | input | 1 | 1 turns off the checksum byte |
| cfg_chk_classic | input | 1 | 1 selects the classic checksum, 0 the enhanced checksum |
| cfg_len_by_id | input | 1 | 1 takes the length from identifier bits 5:4 |
| cfg_len_field | input | LEN_W | Data byte count minus one, used when `cfg_len_by_id` = 0 |
| frame_id | input | 6 | Frame identifier for a master |
| wr_data | input | 8 | Data byte to publish |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Write port accepts a byte |
| tx_data | output | 8 | Byte to the serialiser |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Serialiser accepts a byte |
| rx_data | input | 8 | Byte from the deserialiser |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_ready | output | 1 | Block accepts a received byte |
| rd_data | output | 8 | Subscribed data byte |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_ready | input | 1 | Reader accepts a byte |
| resp_done | output | 1 | One-cycle end-of-response pulse |
| err_parity | output | 1 | Sticky identifier parity mismatch |
| err_chk | output | 1 | Sticky checksum mismatch |
| err_ignore | output | 1 | Sticky flag: frame ignored |

## Verification
The bench builds the block with the default `LEN_W` = 8. This makes a field value of 255 the longest legal response: 256 data bytes, with the counter's last index at its top code and the checksum carry folded back many times. A field value of 0 gives the one-byte response at the other end. The 8-bit field also leaves room for all four identifier-derived lengths and both checksum variants. Every frame runs under ready patterns that stall on both the transmit and read sides. This checks that stalls move neither the byte order nor the done cycle.

// File: rtl/lin_resp_pkg.sv
`timescale 1ns/1ps
// lin_resp_pkg
// Shared widths and types for the LIN response controller.
// Assumes LIN byte framing: 8-bit bytes and 6-bit identifiers.
package lin_resp_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 6;

    // Node action encoding; the reserved code behaves as ignore.
    typedef enum logic [1:0] {
        ACT_PUBLISH   = 2'b00,
        ACT_SUBSCRIBE = 2'b01,
        ACT_IGNORE    = 2'b10,
        ACT_RESERVED  = 2'b11
    } node_act_e;

    // Frame phases of the controller.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_HDR  = 2'b01,
        PH_DATA = 2'b10,
        PH_CHK  = 2'b11
    } frame_phase_e;

    // Per-frame options captured at frame start.
    typedef struct packed {
        logic      is_master;
        node_act_e act;
        logic      par_off;
        logic      chk_off;
        logic      chk_classic;
        logic      len_by_id;
    } frame_cfg_t;

endpackage

// File: rtl/lin_pid_par.sv
`timescale 1ns/1ps
// lin_pid_par
// Combinational identifier parity: returns the two parity bits
// {P1, P0} for a 6-bit identifier. P0 is even parity over bits 0,1,2,4.
// P1 is odd parity over bits 1,3,4,5.
// Assumes ID_W is 6; other widths are not meaningful for LIN.
module lin_pid_par
    import lin_resp_pkg::*;
(
    input  logic [ID_W-1:0] id,
    output logic [1:0]      par
);

    // Parity pair for the identifier
    always_comb begin
        par[0] = id[0] ^ id[1] ^ id[2] ^ id[4];
        par[1] = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    end

endmodule

// File: rtl/lin_len_dec.sv
`timescale 1ns/1ps
// lin_len_dec
// Finds the index of the last data byte: byte count minus one.
// It uses either the length field or identifier bits 5:4.
// Assumes LEN_W >= 3 so that the identifier-derived index 7 fits.
module lin_len_dec #(
    parameter int LEN_W = 8
) (
    input  logic             len_by_id,
    input  logic [LEN_W-1:0] len_field,
    input  logic [1:0]       id_code,
    output logic [LEN_W-1:0] last_idx
);

    // Pick the last-byte index from the selected source
    always_comb begin
        if (!len_by_id) begin
            last_idx = len_field;
        end else begin
            case (id_code)
                2'b10:   last_idx = LEN_W'(3);
                2'b11:   last_idx = LEN_W'(7);
                default: last_idx = LEN_W'(1);
            endcase
        end
    end

endmodule

// File: rtl/lin_cksum_acc.sv
`timescale 1ns/1ps
// lin_cksum_acc
// Running sum with end-around carry. A carry out of the top bit is
// added back into bit 0. 'trial' shows the sum that would result from
// adding add_val, so that a received checksum byte can be tested
// without storing it.
// Assumes init and add are never both high.
module lin_cksum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic [W-1:0] init_val,
    input  logic         add,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum_q,
    output logic [W-1:0] trial
);

    logic [W:0] raw;

    // One end-around-carry addition
    always_comb begin
        raw   = {1'b0, sum_q} + {1'b0, add_val};
        trial = raw[W-1:0] + W'(raw[W]);
    end

    // Load or accumulate the sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (init) begin
            sum_q <= init_val;
        end else if (add) begin
            sum_q <= trial;
        end
    end

    AST_SUM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (sum_q == $past(init_val)));                         // R9
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !add) |=> $stable(sum_q));                          // R9

endmodule

// File: rtl/lin_resp_ctrl.sv
`timescale 1ns/1ps
// lin_resp_ctrl
// Byte-level LIN frame controller: protected identifier, response length,
// publish/subscribe/ignore data path, checksum, and sticky error flags.
// Assumes break and sync have already been handled by the serialiser.
// Handshakes pass straight through with no buffering, and frame_start
// may abort a frame that is running.
module lin_resp_ctrl
    import lin_resp_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cfg_master,
    input  logic [1:0]        cfg_action,
    input  logic              cfg_parity_off,
    input  logic              cfg_chk_off,
    input  logic              cfg_chk_classic,
    input  logic              cfg_len_by_id,
    input  logic [LEN_W-1:0]  cfg_len_field,
    input  logic [5:0]        frame_id,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              resp_done,
    output logic              err_parity,
    output logic              err_chk,
    output logic              err_ignore
);

    localparam logic [BYTE_W-1:0] ALL_ONES = '1;

    frame_phase_e      phase_q;
    frame_cfg_t        cfg_q;
    logic [ID_W-1:0]   id_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  last_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              done_q;
    logic              perr_q;
    logic              cerr_q;
    logic              ierr_q;

    logic              publishing;
    logic              moves_data;
    logic [ID_W-1:0]   par_id;
    logic [1:0]        par_bits;
    logic [BYTE_W-1:0] pid_tx;
    logic [BYTE_W-1:0] hdr_byte;
    logic              par_bad;
    logic [LEN_W-1:0]  last_idx;
    logic              hdr_fire;
    logic              data_fire;
    logic              chk_fire;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] sum_q;
    logic [BYTE_W-1:0] sum_trial;
    logic              ck_init;
    logic [BYTE_W-1:0] ck_init_val;

    // Role and identifier decode for the current frame
    always_comb begin
        publishing = (cfg_q.act == ACT_PUBLISH);
        moves_data = (cfg_q.act == ACT_PUBLISH) || (cfg_q.act == ACT_SUBSCRIBE);
        par_id     = cfg_q.is_master ? id_q : rx_data[ID_W-1:0];
        pid_tx     = cfg_q.par_off ? {2'b00, id_q} : {par_bits, id_q};
        hdr_byte   = cfg_q.is_master ? pid_tx : rx_data;
        par_bad    = !cfg_q.par_off && (rx_data[BYTE_W-1:ID_W] != par_bits);
    end

    lin_pid_par u_pid_par (
        .id  (par_id),
        .par (par_bits)
    );

    lin_len_dec #(
        .LEN_W (LEN_W)
    ) u_len_dec (
        .len_by_id (cfg_q.len_by_id),
        .len_field (len_q),
        .id_code   (par_id[5:4]),
        .last_idx  (last_idx)
    );

    // Byte routing and handshake steering for each phase
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = '0;
        wr_ready  = 1'b0;
        rx_ready  = 1'b0;
        rd_valid  = 1'b0;
        rd_data   = '0;
        hdr_fire  = 1'b0;
        data_fire = 1'b0;
        chk_fire  = 1'b0;
        byte_in   = rx_data;
        case (phase_q)
            PH_HDR: begin
                if (cfg_q.is_master) begin
                    tx_valid = 1'b1;
                    tx_data  = pid_tx;
                    hdr_fire = tx_ready;
                end else begin
                    rx_ready = 1'b1;
                    hdr_fire = rx_valid;
                end
            end
            PH_DATA: begin
                if (publishing) begin
                    tx_valid  = wr_valid;
                    tx_data   = wr_valid ? wr_data : '0;
                    wr_ready  = tx_ready;
                    data_fire = wr_valid && tx_ready;
                    byte_in   = wr_data;
                end else begin
                    rd_valid  = rx_valid;
                    rd_data   = rx_valid ? rx_data : '0;
                    rx_ready  = rd_ready;
                    data_fire = rx_valid && rd_ready;
                end
            end
            PH_CHK: begin
                if (publishing) begin
                    tx_valid = 1'b1;
                    tx_data  = ~sum_q;
                    chk_fire = tx_ready;
                end else begin
                    rx_ready = 1'b1;
                    chk_fire = rx_valid;
                end
            end
            default: ;
        endcase
    end

    // Checksum seeding: enhanced starts from the identifier byte
    always_comb begin
        ck_init     = (phase_q == PH_HDR) && hdr_fire && !frame_start;
        ck_init_val = cfg_q.chk_classic ? '0 : hdr_byte;
    end

    lin_cksum_acc #(
        .W (BYTE_W)
    ) u_cksum (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (ck_init),
        .init_val (ck_init_val),
        .add      (data_fire && !frame_start),
        .add_val  (byte_in),
        .sum_q    (sum_q),
        .trial    (sum_trial)
    );

    // Frame sequencing, byte counting and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
            id_q    <= '0;
            len_q   <= '0;
            last_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            perr_q  <= 1'b0;
            cerr_q  <= 1'b0;
            ierr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                cfg_q.is_master   <= cfg_master;
                cfg_q.act         <= node_act_e'(cfg_action);
                cfg_q.par_off     <= cfg_parity_off;
                cfg_q.chk_off     <= cfg_chk_off;
                cfg_q.chk_classic <= cfg_chk_classic;
                cfg_q.len_by_id   <= cfg_len_by_id;
                id_q              <= frame_id;
                len_q             <= cfg_len_field;
                cnt_q             <= '0;
                perr_q            <= 1'b0;
                cerr_q            <= 1'b0;
                ierr_q            <= 1'b0;
                phase_q           <= PH_HDR;
            end else begin
                case (phase_q)
                    PH_HDR: begin
                        if (hdr_fire) begin
                            cnt_q  <= '0;
                            last_q <= last_idx;
                            if (!cfg_q.is_master && par_bad) begin
                                perr_q <= 1'b1;
                            end
                            if (moves_data) begin
                                phase_q <= PH_DATA;
                            end else begin
                                phase_q <= PH_IDLE;
                                ierr_q  <= 1'b1;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (data_fire) begin
                            if (cnt_q == last_q) begin
                                if (cfg_q.chk_off) begin
                                    phase_q <= PH_IDLE;
                                    done_q  <= 1'b1;
                                end else begin
                                    phase_q <= PH_CHK;
                                end
                            end else begin
                                cnt_q <= cnt_q + LEN_W'(1);
                            end
                        end
                    end
                    PH_CHK: begin
                        if (chk_fire) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                            if (!publishing && (sum_trial != ALL_ONES)) begin
                                cerr_q <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign resp_done  = done_q;
    assign err_parity = perr_q;
    assign err_chk    = cerr_q;
    assign err_ignore = ierr_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);                                    // R12
    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!err_parity && !err_chk && !err_ignore));    // R13
    AST_IGNORE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ignore) |-> !resp_done);                            // R8
    AST_HDR_ID_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HDR && cfg_q.is_master) |-> (tx_data[ID_W-1:0] == id_q)); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> (cnt_q <= last_q));                  // R4
    AST_CHK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CHK && publishing && !tx_ready && !frame_start)
        |=> (tx_valid && $stable(tx_data)));                          // R9
    AST_NO_CHK_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.chk_off && !frame_start) |=> !$rose(err_chk));         // R11

endmodule

// File: tb/test_lin_resp_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model computes byte streams, counts
// and flags, and each clock the outputs are compared against it.
module test_lin_resp_ctrl;

    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             frame_start;
    logic             cfg_master;
    logic [1:0]       cfg_action;
    logic             cfg_parity_off, cfg_chk_off, cfg_chk_classic, cfg_len_by_id;
    logic [LEN_W-1:0] cfg_len_field;
    logic [5:0]       frame_id;
    logic [7:0]       wr_data, tx_data, rx_data, rd_data;
    logic             wr_valid, wr_ready, tx_valid, tx_ready;
    logic             rx_valid, rx_ready, rd_valid, rd_ready;
    logic             resp_done, err_parity, err_chk, err_ignore;

    always #2 clk = ~clk;

    lin_resp_ctrl #(.LEN_W(LEN_W)) i_lin_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_master(cfg_master), .cfg_action(cfg_action),
        .cfg_parity_off(cfg_parity_off), .cfg_chk_off(cfg_chk_off),
        .cfg_chk_classic(cfg_chk_classic), .cfg_len_by_id(cfg_len_by_id),
        .cfg_len_field(cfg_len_field), .frame_id(frame_id),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .resp_done(resp_done), .err_parity(err_parity),
        .err_chk(err_chk), .err_ignore(err_ignore)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_tx_q[$];
    string      exp_tx_tag[$];
    logic [7:0] exp_rd_q[$];
    logic [7:0] wr_src_q[$];
    logic [7:0] rx_src_q[$];
    int  items_left = 0;
    bit  cur_ignore = 1'b0;
    bit  exp_done = 1'b0;
    bit  mon_on = 1'b0;
    int  done_seen = 0;
    string cur_tag = "R6";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] eadd(input logic [7:0] a, input logic [7:0] b);
        int t;
        t = int'(a) + int'(b);
        if (t > 255) t -= 255;
        return t[7:0];
    endfunction

    function automatic logic [7:0] full_pid(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    // Ready patterns with periodic stalls
    initial begin
        int cyc = 0;
        tx_ready = 1'b0;
        rd_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = (cyc % 5) != 3;
            rd_ready = (cyc % 7) != 2;
        end
    end

    // Write-port source
    initial begin
        wr_valid = 1'b0;
        wr_data  = '0;
        forever begin
            @(negedge clk);
            if (wr_src_q.size() > 0) begin
                wr_valid = 1'b1;
                wr_data  = wr_src_q[0];
            end else begin
                wr_valid = 1'b0;
                wr_data  = '0;
            end
            #1.5;
            if (wr_valid && wr_ready) void'(wr_src_q.pop_front());
        end
    end

    // Receive-port source
    initial begin
        rx_valid = 1'b0;
        rx_data  = '0;
        forever begin
            @(negedge clk);
            if (rx_src_q.size() > 0) begin
                rx_valid = 1'b1;
                rx_data  = rx_src_q[0];
            end else begin
                rx_valid = 1'b0;
                rx_data  = '0;
            end
            #1.5;
            if (rx_valid && rx_ready) void'(rx_src_q.pop_front());
        end
    end

    // Per-clock monitor: bytes, order and done timing against the model
    initial begin
        forever begin
            bit nxt;
            @(negedge clk);
            #1.5;
            if (mon_on) begin
                nxt = 1'b0;
                check(resp_done === exp_done, "R12", "done timing", resp_done, exp_done);
                if (resp_done) done_seen++;
                if (tx_valid && tx_ready) begin
                    if (exp_tx_q.size() == 0) begin
                        check(1'b0, cur_tag, "unexpected tx byte", tx_data, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_tx_q.pop_front();
                        t = exp_tx_tag.pop_front();
                        check(tx_data === e, t, "tx byte", tx_data, e);
                    end
                    if (items_left > 0) begin
                        items_left--;
                        if (items_left == 0 && !cur_ignore) nxt = 1'b1;
                    end
                end
                if (rx_valid && rx_ready) begin
                    if (items_left > 0) begin
                        items_left--;
                        if (items_left == 0 && !cur_ignore) nxt = 1'b1;
                    end else begin
                        check(1'b0, cur_tag, "unexpected rx accept", rx_data, 0);
                    end
                end
                if (rd_valid && rd_ready) begin
                    if (exp_rd_q.size() == 0) begin
                        check(1'b0, cur_tag, "unexpected rd byte", rd_data, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_rd_q.pop_front();
                        check(rd_data === e, "R7", "rd byte", rd_data, e);
                    end
                end
                exp_done = nxt;
            end
        end
    end

    task automatic run_frame(input bit master, input logic [1:0] act,
                             input bit par_off, input bit chk_off, input bit classic,
                             input bit by_id, input logic [7:0] lenf,
                             input logic [5:0] id, input bit bad_par,
                             input bit bad_chk, input logic [7:0] seed);
        logic [7:0] pid, s, d, c;
        int n;
        bit ign;
        bit exp_perr, exp_cerr;
        ign = act[1];
        if (master) begin
            pid = par_off ? {2'b00, id} : full_pid(id);
            exp_tx_q.push_back(pid);
            exp_tx_tag.push_back("R2");
        end else begin
            pid = full_pid(id) ^ (bad_par ? 8'h40 : 8'h00);
            rx_src_q.push_back(pid);
        end
        exp_perr = !master && bad_par && !par_off;
        exp_cerr = 1'b0;
        if (by_id) n = (id[5:4] == 2'b11) ? 8 : (id[5:4] == 2'b10) ? 4 : 2;
        else       n = int'(lenf) + 1;
        s = classic ? 8'h00 : pid;
        cur_tag = ign ? "R8" : (act[0] ? "R7" : "R6");
        if (!ign) begin
            for (int k = 0; k < n; k++) begin
                d = 8'(int'(seed) * (k + 1) + k * 53);
                s = eadd(s, d);
                if (act[0]) begin
                    rx_src_q.push_back(d);
                    exp_rd_q.push_back(d);
                end else begin
                    wr_src_q.push_back(d);
                    exp_tx_q.push_back(d);
                    exp_tx_tag.push_back("R6");
                end
            end
            if (!chk_off) begin
                if (act[0]) begin
                    c = ~s ^ (bad_chk ? 8'h01 : 8'h00);
                    rx_src_q.push_back(c);
                    exp_cerr = bad_chk;
                end else begin
                    exp_tx_q.push_back(~s);
                    exp_tx_tag.push_back("R9");
                end
            end
        end
        items_left = 1 + (ign ? 0 : n + (chk_off ? 0 : 1));
        cur_ignore = ign;
        done_seen  = 0;
        @(negedge clk);
        cfg_master = master; cfg_action = act; cfg_parity_off = par_off;
        cfg_chk_off = chk_off; cfg_chk_classic = classic; cfg_len_by_id = by_id;
        cfg_len_field = lenf; frame_id = master ? id : 6'h00;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        #1.5;
        check(!err_parity && !err_chk && !err_ignore, "R13", "flags after start",
              {err_parity, err_chk, err_ignore}, 0);
        while (items_left != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #1.5;
        check(err_parity === exp_perr, "R3", "parity flag", err_parity, exp_perr);
        check(err_chk === exp_cerr, chk_off ? "R11" : "R10", "checksum flag", err_chk, exp_cerr);
        check(err_ignore === ign, "R8", "ignore flag", err_ignore, ign);
        check(done_seen == (ign ? 0 : 1), "R12", "done pulses", done_seen, ign ? 0 : 1);
        check(exp_tx_q.size() == 0 && exp_rd_q.size() == 0, "R4", "all bytes moved",
              exp_tx_q.size() + exp_rd_q.size(), 0);
        check(!tx_valid && !rd_valid && !rx_ready && !wr_ready, cur_tag, "idle after frame",
              {tx_valid, rd_valid, rx_ready, wr_ready}, 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; cfg_master = 1'b0; cfg_action = 2'b00;
        cfg_parity_off = 1'b0; cfg_chk_off = 1'b0; cfg_chk_classic = 1'b0;
        cfg_len_by_id = 1'b0; cfg_len_field = '0; frame_id = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        // R1: reset state
        check(!tx_valid && !rx_ready && !wr_ready && !rd_valid, "R1", "ports after reset",
              {tx_valid, rx_ready, wr_ready, rd_valid}, 0);
        check(!resp_done && !err_parity && !err_chk && !err_ignore, "R1", "flags after reset",
              {resp_done, err_parity, err_chk, err_ignore}, 0);
        mon_on = 1'b1;
        // master publish, enhanced, field length 4 (R2 R4 R6 R9)
        run_frame(1, 2'b00, 0, 0, 0, 0, 8'd3,  6'h15, 0, 0, 8'hC3);
        // master publish, classic, id length code 11 -> 8 (R5 R9)
        run_frame(1, 2'b00, 0, 0, 1, 1, 8'd0,  6'h3A, 0, 0, 8'hF1);
        // master subscribe, enhanced, id code 00 -> 2, good checksum (R5 R7 R10)
        run_frame(1, 2'b01, 0, 0, 0, 1, 8'd0,  6'h0C, 0, 0, 8'h7E);
        // slave subscribe, classic, bad checksum (R10)
        run_frame(0, 2'b01, 0, 0, 1, 0, 8'd5,  6'h21, 0, 1, 8'h99);
        // slave publish, id code 10 -> 4, bad parity (R3 R5)
        run_frame(0, 2'b00, 0, 0, 0, 1, 8'd0,  6'h2B, 1, 0, 8'h42);
        // slave subscribe, bad parity with parity off (R3)
        run_frame(0, 2'b01, 1, 0, 0, 0, 8'd2,  6'h07, 1, 0, 8'hAB);
        // master publish, parity off (R2)
        run_frame(1, 2'b00, 1, 0, 0, 0, 8'd1,  6'h3F, 0, 0, 8'h11);
        // master publish, checksum off, one byte (R11 R4)
        run_frame(1, 2'b00, 0, 1, 0, 0, 8'd0,  6'h09, 0, 0, 8'hFF);
        // slave subscribe, checksum off, id code 01 -> 2 (R11 R5)
        run_frame(0, 2'b01, 0, 1, 0, 1, 8'd0,  6'h11, 0, 0, 8'h5D);
        // ignore and reserved actions (R8)
        run_frame(1, 2'b10, 0, 0, 0, 0, 8'd3,  6'h01, 0, 0, 8'h00);
        run_frame(0, 2'b11, 0, 0, 0, 0, 8'd3,  6'h22, 0, 0, 8'h00);
        // longest response, 256 bytes (R4 R7 R10)
        run_frame(1, 2'b01, 0, 0, 0, 0, 8'd255, 6'h30, 0, 0, 8'hB7);
        // slave publish, classic (R6 R9)
        run_frame(0, 2'b00, 0, 0, 1, 0, 8'd2,  6'h1E, 0, 0, 8'hE5);
        summary();
        $finish;
    end

endmodule